// File: doc/BRIEF.md
# Two-Wire Register Access Master with Acknowledge Polling

This block is a master for a two-wire register bus. It reads and writes 16-bit registers at 16-bit addresses in one attached slave. The host presents one request: a direction, an address and, for writes, a data word. The block runs the complete bus frame and then returns a one-cycle completion pulse, the read word and an error flag.

A frame opens with a start condition. An 8-bit control header follows, made of a 4-bit device code (a parameter), the fixed 3-bit field 100 and a direction bit. Each byte the master sends is followed by an acknowledge slot that the slave owns. The address is sent low byte first. On a write, the data word follows, low byte first. On a read, the slave returns two bytes, and after each one the master drives its own acknowledge bit. The frame ends with a stop condition.

The clock line is driven push-pull. The data line is open-drain: the master can only pull it low or release it. The bit rate comes from a cycle divider, and acknowledge polling is bounded by a retry parameter.

Top module: `mgmt_master`

## Requirements
- R1: Out of reset, and whenever no frame is in progress, `req_ready` is 1, the clock line is high and the master releases the data line (`mgmt_sda_oe` = 0).
- R2: A frame opens with the data line falling while the clock is high. Eight bits follow, most significant first: `CTRL_CODE` (default 1010), then 100, then the direction bit (0 = write, 1 = read).
- R3: The address is sent as bits 7:0, then bits 15:8, each byte MSB first. Every byte the master sends is followed by one acknowledge slot, during which the master releases the data line.
- R4: On a write, the data word follows the address as bits 7:0, then bits 15:8, each byte MSB first and each with its own acknowledge slot.
- R5: In an acknowledge slot, a sampled 0 moves the frame on to the next byte. A sampled 1 causes another acknowledge clock pulse, up to `RETRY_MAX` pulses in total for that byte.
- R6: If the last allowed pulse still samples 1, `rsp_err` is set and the frame continues to its normal end. `rsp_err` is cleared when a new request is accepted.
- R7: On a read, the master releases the data line for both data bytes. After the first byte it drives a 0, and after the second it releases the line, giving a 1. `rsp_rdata` equals {second byte, first byte}.
- R8: Every frame ends with the data line rising while the clock is high. `rsp_done` is then high for exactly one cycle, with `req_ready` high in the same cycle.
- R9: Every low phase of the clock lasts `DIV` cycles. So does every high phase inside a frame.
- R10: Within a frame, the data line changes while the clock is high exactly twice: once at the start and once at the stop.
- R11: While a frame is in progress, `req_ready` is 0 and `req_valid` has no effect. Only one frame is produced per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken when valid and ready are both high |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result, valid at `rsp_done` after a read |
| rsp_err | output | 1 | An acknowledge never arrived within the retry limit |
| mgmt_scl | output | 1 | Bus clock line |
| mgmt_sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mgmt_sda_in | input | 1 | Sampled level of the data line |

## Verification
The bench attaches a behavioural slave to the open-drain line. This slave decodes start, stop, bytes and acknowledge slots on its own, so a wrong header code, byte order, bit order or master-acknowledge value shows up directly.

Writes and reads use address and data values with distinct high and low bytes, which exposes any byte swap. Acknowledge patterns are varied from byte to byte: none withheld, withheld for fewer pulses than the limit, and withheld beyond the limit on a chosen byte. These cases separate a correct retry count from an off-by-one, and a fatal error from a frame that aborts. A request held valid through a busy frame shows that requests are ignored while a frame is running. Throughout, a cycle monitor checks phase lengths and any data-line movement while the clock is high.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    // Bus phase of the sequencer; each non-idle phase lasts one divider period
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_LO,
        PH_HI,
        PH_STOP_LO,
        PH_STOP_HI,
        PH_STOP_REL
    } phase_e;

    // Byte position inside one frame
    typedef enum logic [2:0] {
        SEG_CTRL,
        SEG_ADR_LO,
        SEG_ADR_HI,
        SEG_DAT_LO,
        SEG_DAT_HI
    } seg_e;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;
    localparam int SLOT_W   = 4;          // bit index 0..7 data, 8 = acknowledge
    localparam logic [2:0] CTRL_MID = 3'b100;

    typedef struct packed {
        logic              rd;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } req_s;

    // Byte the master shifts out in a given segment
    function automatic logic [BYTE_W-1:0] seg_byte(input seg_e s, input req_s r,
                                                   input logic [3:0] code);
        case (s)
            SEG_CTRL:   return {code, CTRL_MID, r.rd};
            SEG_ADR_LO: return r.addr[7:0];
            SEG_ADR_HI: return r.addr[15:8];
            SEG_DAT_LO: return r.wdata[7:0];
            default:    return r.wdata[15:8];
        endcase
    endfunction

    // True when the slave owns the data bits of this segment
    function automatic logic slave_sends(input seg_e s, input logic rd);
        return rd && (s == SEG_DAT_LO || s == SEG_DAT_HI);
    endfunction

endpackage

// File: rtl/mgmt_bit_timer.sv
module mgmt_bit_timer #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == LAST);

endmodule

// File: rtl/mgmt_ack_poll.sv
module mgmt_ack_poll #(
    parameter int RETRY_MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic final_try
);
    localparam int TW = $clog2(RETRY_MAX + 1);

    logic [TW-1:0] tries;

    always_ff @(posedge clk) begin
        if (rst || clr)
            tries <= '0;
        else if (miss && !final_try)
            tries <= tries + 1'b1;
    end

    assign final_try = (tries == TW'(RETRY_MAX - 1));

    // Retry counter never runs past the configured pulse budget
    assert_tries_bound_R5: assert property (@(posedge clk) disable iff (rst)
        tries < TW'(RETRY_MAX));

endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mgmt_pkg::*;
#(
    parameter logic [3:0] CTRL_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              final_try,
    input  logic              req_valid,
    input  req_s              req_in,
    input  logic              sda_in,
    output logic              req_ready,
    output logic              run,
    output logic              ack_miss,
    output logic              ack_clr,
    output logic              scl,
    output logic              sda_oe,
    output logic              done,
    output logic              err,
    output logic [WORD_W-1:0] rd_data
);
    phase_e              phase;
    seg_e                seg;
    logic [SLOT_W-1:0]   bitn;
    req_s                req_q;
    logic [BYTE_W-1:0]   rx;
    logic [BYTE_W-1:0]   rd_lo;
    logic [BYTE_W-1:0]   cur_byte;
    logic                slave_tx;
    logic                pull;
    logic                slot_end;
    logic                retry;

    assign cur_byte  = seg_byte(seg, req_q, CTRL_CODE);
    assign slave_tx  = slave_sends(seg, req_q.rd);
    assign req_ready = (phase == PH_IDLE);
    assign run       = (phase != PH_IDLE);
    assign scl       = (phase == PH_IDLE) || (phase == PH_START) || (phase == PH_HI)
                    || (phase == PH_STOP_HI) || (phase == PH_STOP_REL);

    // End of a high phase in the acknowledge / master-bit slot
    assign slot_end  = (phase == PH_HI) && tick && bitn[3];
    assign ack_miss  = slot_end && !slave_tx && sda_in;
    assign retry     = ack_miss && !final_try;
    assign ack_clr   = (phase == PH_IDLE) || (slot_end && !retry);

    // Level the master wants on the data line for the current state
    always_comb begin
        pull = 1'b0;
        unique case (phase)
            PH_START, PH_STOP_LO, PH_STOP_HI: pull = 1'b1;
            PH_LO, PH_HI: begin
                if (!bitn[3])
                    pull = slave_tx ? 1'b0 : !cur_byte[~bitn[2:0]];
                else
                    pull = slave_tx && (seg == SEG_DAT_LO);
            end
            default: pull = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            seg     <= SEG_CTRL;
            bitn    <= '0;
            req_q   <= '0;
            rx      <= '0;
            rd_lo   <= '0;
            rd_data <= '0;
            err     <= 1'b0;
            done    <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            done   <= 1'b0;
            // one-cycle lag keeps data edges clear of clock edges
            sda_oe <= pull;
            unique case (phase)
                PH_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        err   <= 1'b0;
                        seg   <= SEG_CTRL;
                        bitn  <= '0;
                        phase <= PH_START;
                    end
                end
                PH_START: if (tick) phase <= PH_LO;
                PH_LO:    if (tick) phase <= PH_HI;
                PH_HI: begin
                    if (tick) begin
                        if (!bitn[3]) begin
                            if (slave_tx) begin
                                rx <= {rx[6:0], sda_in};
                                if (bitn == 4'd7) begin
                                    if (seg == SEG_DAT_LO)
                                        rd_lo <= {rx[6:0], sda_in};
                                    else
                                        rd_data <= {rx[6:0], sda_in, rd_lo};
                                end
                            end
                            bitn  <= bitn + 4'd1;
                            phase <= PH_LO;
                        end else if (retry) begin
                            phase <= PH_LO;
                        end else begin
                            if (ack_miss)
                                err <= 1'b1;
                            bitn <= '0;
                            if (seg == SEG_DAT_HI)
                                phase <= PH_STOP_LO;
                            else begin
                                seg   <= seg_e'(seg + 3'd1);
                                phase <= PH_LO;
                            end
                        end
                    end
                end
                PH_STOP_LO: if (tick) phase <= PH_STOP_HI;
                PH_STOP_HI: if (tick) phase <= PH_STOP_REL;
                PH_STOP_REL: begin
                    if (tick) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Idle bus: clock high and data released
    assert_idle_bus_R1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (scl && !sda_oe));

    // Data line does not move during a bit's high phase
    assert_sda_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_HI && $past(phase) == PH_HI) |-> $stable(sda_oe));

    // Completion is a single pulse seen only on an idle block
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> req_ready);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // Error flag rises only after a sampled missing acknowledge
    assert_err_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(sda_in));

    // Latched request cannot change while a frame is running
    assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> $stable(req_q));

endmodule

// File: rtl/mgmt_master.sv
module mgmt_master
    import mgmt_pkg::*;
#(
    parameter int         DIV       = 8,
    parameter int         RETRY_MAX = 4,
    parameter logic [3:0] CTRL_CODE = 4'b1010
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_read,
    input  logic [15:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_done,
    output logic [15:0] rsp_rdata,
    output logic        rsp_err,
    output logic        mgmt_scl,
    output logic        mgmt_sda_oe,
    input  logic        mgmt_sda_in
);
    req_s req_in;
    logic run;
    logic tick;
    logic ack_miss;
    logic ack_clr;
    logic final_try;

    always_comb begin
        req_in.rd    = req_read;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
    end

    mgmt_bit_timer #(.DIV(DIV)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    mgmt_ack_poll #(.RETRY_MAX(RETRY_MAX)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .clr       (ack_clr),
        .miss      (ack_miss),
        .final_try (final_try)
    );

    mgmt_seq #(.CTRL_CODE(CTRL_CODE)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .final_try (final_try),
        .req_valid (req_valid),
        .req_in    (req_in),
        .sda_in    (mgmt_sda_in),
        .req_ready (req_ready),
        .run       (run),
        .ack_miss  (ack_miss),
        .ack_clr   (ack_clr),
        .scl       (mgmt_scl),
        .sda_oe    (mgmt_sda_oe),
        .done      (rsp_done),
        .err       (rsp_err),
        .rd_data   (rsp_rdata)
    );

endmodule

// File: tb/mgmt_master_tb.sv
`timescale 1ns/1ps
module mgmt_master_tb;
    localparam int         DIV   = 4;
    localparam int         RETRY = 4;
    localparam logic [3:0] CODE  = 4'b1010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_read = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_done;
    logic [15:0] rsp_rdata;
    logic        rsp_err;
    logic        scl;
    logic        sda_oe;
    logic        sda_line;
    logic        drive_low = 1'b0;

    always #2.5 clk = ~clk;

    assign sda_line = ~(sda_oe | drive_low);

    mgmt_master #(.DIV(DIV), .RETRY_MAX(RETRY), .CTRL_CODE(CODE)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_read    (req_read),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err),
        .mgmt_scl    (scl),
        .mgmt_sda_oe (sda_oe),
        .mgmt_sda_in (sda_line)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural slave ----------------
    int          pos = 5;
    int          sbit = 0;
    int          tries = 0;
    bit          rd_mode = 1'b0;
    logic [7:0]  cur = '0;
    logic [7:0]  got [5];
    int          pulses [5];
    int          nack [5];
    logic        mack [2];
    logic [15:0] rdval = '0;
    int          starts = 0;
    int          stops = 0;
    int          hi_edges = 0;

    always @(negedge sda_line) begin
        if (scl === 1'b1) begin
            starts++;
            hi_edges++;
            pos = 0; sbit = 0; tries = 0; rd_mode = 1'b0; cur = '0;
            for (int i = 0; i < 5; i++) begin got[i] = '0; pulses[i] = 0; end
        end
    end

    always @(posedge sda_line) begin
        if (scl === 1'b1) begin
            stops++;
            hi_edges++;
        end
    end

    always @(posedge scl) begin
        if (pos < 5) begin
            if (sbit < 8) begin
                if (!(rd_mode && pos >= 3)) cur = {cur[6:0], sda_line};
                sbit++;
                if (sbit == 8 && !(rd_mode && pos >= 3)) begin
                    got[pos] = cur;
                    if (pos == 0) rd_mode = cur[0];
                end
            end else if (rd_mode && pos >= 3) begin
                mack[pos-3] = sda_line;
                pos++; sbit = 0;
            end else begin
                tries++;
                pulses[pos] = tries;
                if (sda_line == 1'b0 || tries == RETRY) begin
                    pos++; sbit = 0; tries = 0;
                end
            end
        end
    end

    always @(negedge scl) begin
        if (pos < 5 && sbit < 8 && rd_mode && pos >= 3)
            drive_low = ~rdval[(pos-3)*8 + 7 - sbit];
        else if (pos < 5 && sbit == 8 && !(rd_mode && pos >= 3))
            drive_low = (tries >= nack[pos]);
        else
            drive_low = 1'b0;
    end

    // ---------------- per-clock phase-length reference (R9) ----------------
    int   run_len = 0;
    logic scl_prev = 1'b1;
    bit   hi_ok = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (req_ready) hi_ok = 1'b0;
            if (scl == scl_prev) run_len++;
            else begin
                if (scl) begin
                    chk("R9", "clock low length", run_len, DIV);
                    hi_ok = 1'b1;
                end else if (hi_ok) begin
                    chk("R9", "clock high length", run_len, DIV);
                end
                run_len = 1;
            end
            scl_prev = scl;
        end
    end

    // ---------------- transaction driver and checker ----------------
    task automatic txn(input bit rd, input logic [15:0] addr, input logic [15:0] wdata,
                       input logic [15:0] rdv, input int hold);
        int  cyc;
        bit  exp_err;
        rdval = rdv; starts = 0; stops = 0; hi_edges = 0;
        @(negedge clk);
        req_valid = 1'b1; req_read = rd; req_addr = addr; req_wdata = wdata;
        @(negedge clk);
        chk("R11", "ready while busy", int'(req_ready), 0);
        // R11: keep a different request valid while busy
        req_addr = ~addr; req_wdata = ~wdata; req_read = ~rd;
        cyc = 1;
        while (rsp_done !== 1'b1 && cyc < 20000) begin
            if (cyc >= hold) req_valid = 1'b0;
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk("R8", "completion seen", int'(rsp_done === 1'b1), 1);
        chk("R8", "ready at completion", int'(req_ready), 1);
        chk("R2", "control byte", int'(got[0]), int'({CODE, 3'b100, rd}));
        chk("R3", "address low byte", int'(got[1]), int'(addr[7:0]));
        chk("R3", "address high byte", int'(got[2]), int'(addr[15:8]));
        exp_err = 1'b0;
        for (int i = 0; i < 5; i++) begin
            if (!(rd && i >= 3)) begin
                chk("R5", $sformatf("ack pulses byte %0d", i), pulses[i],
                    (nack[i] + 1 < RETRY) ? nack[i] + 1 : RETRY);
                if (nack[i] >= RETRY) exp_err = 1'b1;
            end
        end
        if (rd) begin
            chk("R7", "master ack after low byte", int'(mack[0]), 0);
            chk("R7", "master bit after high byte", int'(mack[1]), 1);
            chk("R7", "read word", int'(rsp_rdata), int'(rdv));
        end else begin
            chk("R4", "data low byte", int'(got[3]), int'(wdata[7:0]));
            chk("R4", "data high byte", int'(got[4]), int'(wdata[15:8]));
        end
        chk("R6", "error flag", int'(rsp_err), int'(exp_err));
        chk("R8", "start count", starts, 1);
        chk("R8", "stop count", stops, 1);
        chk("R10", "data edges under high clock", hi_edges, 2);
        @(negedge clk);
        chk("R8", "completion pulse width", int'(rsp_done), 0);
        repeat (3 * DIV) @(negedge clk);
        chk("R11", "no extra frame", starts, 1);
        chk("R1", "idle clock", int'(scl), 1);
        chk("R1", "idle data", int'(sda_line), 1);
    endtask

    task automatic set_nack(input int a, input int b, input int c, input int d, input int e);
        nack[0] = a; nack[1] = b; nack[2] = c; nack[3] = d; nack[4] = e;
    endtask

    bit finished = 1'b0;

    initial begin
        set_nack(0, 0, 0, 0, 0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ready after reset", int'(req_ready), 1);
        chk("R1", "clock after reset", int'(scl), 1);
        chk("R1", "data after reset", int'(sda_line), 1);
        chk("R1", "done after reset", int'(rsp_done), 0);
        chk("R1", "err after reset", int'(rsp_err), 0);

        set_nack(0, 0, 0, 0, 0);
        txn(1'b0, 16'h1234, 16'hABCD, 16'h0000, 0);
        set_nack(0, 0, 0, 0, 0);
        txn(1'b1, 16'h00F1, 16'h0000, 16'h5AC3, 0);
        set_nack(0, 0, 2, 0, 0);          // R5: below the limit
        txn(1'b0, 16'h8001, 16'h0F70, 16'h0000, 0);
        set_nack(0, 0, 0, 10, 0);         // R6: never acknowledged
        txn(1'b0, 16'hC35A, 16'h9966, 16'h0000, 0);
        set_nack(1, 0, 0, 0, 0);          // R6: flag clears; R5 on header
        txn(1'b1, 16'h7E81, 16'h0000, 16'hA501, 0);
        set_nack(0, RETRY - 1, 0, 0, 0);  // R5: acknowledged on the last pulse
        txn(1'b0, 16'h4422, 16'h1188, 16'h0000, 60);
        set_nack(0, 0, 0, 0, 0);          // R11: request held valid while busy
        txn(1'b1, 16'hFFFE, 16'h0000, 16'h8000, 80);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule